// File: doc/BRIEF.md
# SECDED Word Protector with First-Error Capture

This block guards 64-bit memory words with an extended Hamming code. On the write side it turns each data word into a 72-bit codeword (64 data bits, 7 Hamming check bits, 1 overall parity bit) one cycle after the word is presented. On the read side it takes a 72-bit word and its address and, one cycle later, returns the data with any single flipped bit repaired. It also raises a correctable or an uncorrectable flag alongside that data.

The first failing read is remembered. Its address and an 8-bit syndrome are written into a capture register, and that register is then frozen until software clears it. An IO-read strobe returns a snapshot of the capture register one cycle later, so a maintenance command can report where memory first went bad.

Top module: `secded_guard`

## Requirements
- R1: Codeword layout. Bit 0 makes the parity of all 72 bits even. Bits 1, 2, 4, 8, 16, 32 and 64 are Hamming check bits: the check bit at position 2^k makes the XOR of all positions 1..71 whose index has bit k set equal to zero. Data bits d0..d63 fill the remaining positions 3, 5, 6, 7, 9, ... in ascending order. `enc_word` and `enc_valid` appear one cycle after `wr_valid`.
- R2: A read of an error-free codeword returns its data on `cor_data` with both error flags low. `cor_valid` is high exactly one cycle after `rd_valid`.
- R3: A read with any one of the 72 bits inverted returns the original data, with `err_single` high and `err_double` low.
- R4: A read with two bits inverted raises `err_double` and leaves `err_single` low. The two flags are never high together.
- R5: The syndrome is {overall parity odd, 7-bit Hamming syndrome}. For a single inverted bit, the low 7 bits equal that bit's position.
- R6: Out of reset, the capture register is empty. The first read that raises either flag sets `log_valid` and stores the read address and the syndrome, one cycle after the flags.
- R7: While `log_valid` is high, later errors leave the stored address and syndrome unchanged.
- R8: `log_clear` empties the capture register. If an error arrives in the same cycle as the clear, that error is captured and `log_valid` stays high.
- R9: `io_rd_req` produces `io_rd_ack` one cycle later, together with a snapshot of the valid flag, address and syndrome as they stood when the request was sampled.
- R10: During reset, all valid strobes, flags and capture outputs are low.
- R11: Without `rd_valid`, the contents of `rd_word` have no effect: `cor_valid` and both flags stay low, and nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write data is present |
| wr_data | input | 64 | Data word to encode |
| enc_valid | output | 1 | Encoded word is valid |
| enc_word | output | 72 | Encoded codeword |
| rd_valid | input | 1 | Read word is present |
| rd_addr | input | ADDR_W | Address of the read word |
| rd_word | input | 72 | Codeword read from memory |
| cor_valid | output | 1 | Corrected data is valid |
| cor_data | output | 64 | Corrected data |
| err_single | output | 1 | Correctable error seen |
| err_double | output | 1 | Uncorrectable error seen |
| log_clear | input | 1 | Empty the capture register |
| log_valid | output | 1 | Capture register holds an error |
| io_rd_req | input | 1 | Request a capture snapshot |
| io_rd_ack | output | 1 | Snapshot is valid |
| io_rd_valid | output | 1 | Snapshot valid flag |
| io_rd_addr | output | ADDR_W | Snapshot address |
| io_rd_syn | output | 8 | Snapshot syndrome |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a new capture. The capture happens two edges after the failing read is presented, so the clear has to be raised in the cycle between the read's output edge and the capture edge. The bench times the clear against that window, issues an IO read afterwards, and confirms that the new address was kept. Single-bit flips are also driven at the parity bit, at check-bit positions and at the highest position, so that correction is exercised on both kinds of bit and at both ends of the word.

// File: rtl/secded_pkg.sv
// Shared constants and code helpers for the (72,64) extended Hamming code.
// Assumes positions 1..CW_W-1 hold the Hamming code and position 0 holds
// the overall parity bit.
package secded_pkg;
    parameter int DATA_W = 64;
    parameter int SYN_W  = 7;
    parameter int CHK_W  = SYN_W + 1;
    parameter int CW_W   = DATA_W + CHK_W;

    // True when p is a power of two (a Hamming check position)
    function automatic logic is_pow2(input int p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

    // Scatter data bits into the non-check positions, check bits left zero
    function automatic logic [CW_W-1:0] place_data(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] cw;
        int j;
        cw = '0;
        j = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[j];
                j++;
            end
        end
        return cw;
    endfunction

    // Gather data bits back from the non-check positions
    function automatic logic [DATA_W-1:0] pick_data(input logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                d[j] = cw[p];
                j++;
            end
        end
        return d;
    endfunction

    // XOR of the indices of all set bits in positions 1..CW_W-1
    function automatic logic [SYN_W-1:0] ham_syndrome(input logic [CW_W-1:0] cw);
        logic [SYN_W-1:0] s;
        s = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p]) s = s ^ SYN_W'(p);
        end
        return s;
    endfunction
endpackage

// File: rtl/secded_encoder.sv
// Write-side encoder: builds the 72-bit codeword from a 64-bit data word.
// Assumes one word per cycle at most. Output is registered (1 cycle).
module secded_encoder
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [CW_W-1:0]   out_word
);
    logic [CW_W-1:0]  cw_c;
    logic [SYN_W-1:0] chk_c;

    // Place data, fill check bits so the syndrome is zero, then overall parity
    always_comb begin
        cw_c  = place_data(in_data);
        chk_c = ham_syndrome(cw_c);
        for (int k = 0; k < SYN_W; k++) begin
            cw_c[1 << k] = chk_c[k];
        end
        cw_c[0] = ^cw_c[CW_W-1:1];
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_word <= cw_c;
        end
    end
endmodule

// File: rtl/secded_checker.sv
// Read-side checker: computes the syndrome, repairs a single flipped bit and
// classifies the error. Output is registered (1 cycle). The flags are only
// high when the matching output is valid.
module secded_checker
    import secded_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CW_W-1:0]   in_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_single,
    output logic              out_double,
    output logic [ADDR_W-1:0] out_addr,
    output logic [CHK_W-1:0]  out_syn
);
    localparam int MAX_POS = CW_W - 1;

    logic [SYN_W-1:0] syn_c;
    logic             odd_c;
    logic             single_c;
    logic             double_c;
    logic [CW_W-1:0]  fixed_c;

    // Syndrome, overall parity and classification
    always_comb begin
        syn_c    = ham_syndrome(in_word);
        odd_c    = ^in_word;
        single_c = odd_c && (int'(syn_c) <= MAX_POS);
        double_c = (!odd_c && (syn_c != '0)) || (odd_c && (int'(syn_c) > MAX_POS));
        fixed_c  = in_word;
        if (single_c) fixed_c[syn_c] = ~in_word[syn_c];
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_single <= 1'b0;
            out_double <= 1'b0;
            out_addr   <= '0;
            out_syn    <= '0;
        end else begin
            out_valid  <= in_valid;
            out_single <= in_valid && single_c;
            out_double <= in_valid && double_c;
            if (in_valid) begin
                out_data <= pick_data(fixed_c);
                out_addr <= in_addr;
                out_syn  <= {odd_c, syn_c};
            end
        end
    end
endmodule

// File: rtl/secded_err_log.sv
// First-error capture register and its IO-read snapshot port.
// Assumes err_in is aligned with addr_in/syn_in. A clear in the same
// cycle as an error still captures that error.
module secded_err_log
    import secded_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CHK_W-1:0]  syn_in,
    input  logic              clear,
    input  logic              rd_req,
    output logic              hold_valid,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [CHK_W-1:0]  hold_syn,
    output logic              rd_ack,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CHK_W-1:0]  rd_syn
);
    logic take_c;

    // Capture only when empty or being cleared
    always_comb take_c = err_in && (!hold_valid || clear);

    // Capture register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_addr  <= '0;
            hold_syn   <= '0;
        end else begin
            if (take_c) begin
                hold_valid <= 1'b1;
                hold_addr  <= addr_in;
                hold_syn   <= syn_in;
            end else if (clear) begin
                hold_valid <= 1'b0;
            end
        end
    end

    // IO-read snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ack   <= 1'b0;
            rd_valid <= 1'b0;
            rd_addr  <= '0;
            rd_syn   <= '0;
        end else begin
            rd_ack <= rd_req;
            if (rd_req) begin
                rd_valid <= hold_valid;
                rd_addr  <= hold_addr;
                rd_syn   <= hold_syn;
            end
        end
    end
endmodule

// File: rtl/secded_guard.sv
// Top: encoder on the write path, checker on the read path, and first-error
// capture fed from the checker's registered flags (capture lags flags by 1).
module secded_guard
    import secded_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [63:0]       wr_data,
    output logic              enc_valid,
    output logic [71:0]       enc_word,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [71:0]       rd_word,
    output logic              cor_valid,
    output logic [63:0]       cor_data,
    output logic              err_single,
    output logic              err_double,
    input  logic              log_clear,
    output logic              log_valid,
    input  logic              io_rd_req,
    output logic              io_rd_ack,
    output logic              io_rd_valid,
    output logic [ADDR_W-1:0] io_rd_addr,
    output logic [7:0]        io_rd_syn
);
    logic [ADDR_W-1:0] chk_addr;
    logic [CHK_W-1:0]  chk_syn;
    logic [ADDR_W-1:0] log_addr;
    logic [CHK_W-1:0]  log_syn;
    logic              any_err;

    // Either error class triggers capture
    always_comb any_err = err_single || err_double;

    secded_encoder u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (wr_valid),
        .in_data   (wr_data),
        .out_valid (enc_valid),
        .out_word  (enc_word)
    );

    secded_checker #(.ADDR_W(ADDR_W)) u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rd_valid),
        .in_addr    (rd_addr),
        .in_word    (rd_word),
        .out_valid  (cor_valid),
        .out_data   (cor_data),
        .out_single (err_single),
        .out_double (err_double),
        .out_addr   (chk_addr),
        .out_syn    (chk_syn)
    );

    secded_err_log #(.ADDR_W(ADDR_W)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_in     (any_err),
        .addr_in    (chk_addr),
        .syn_in     (chk_syn),
        .clear      (log_clear),
        .rd_req     (io_rd_req),
        .hold_valid (log_valid),
        .hold_addr  (log_addr),
        .hold_syn   (log_syn),
        .rd_ack     (io_rd_ack),
        .rd_valid   (io_rd_valid),
        .rd_addr    (io_rd_addr),
        .rd_syn     (io_rd_syn)
    );
endmodule

// File: rtl/secded_guard_props.sv
// Checker module holding the temporal properties of secded_guard; bound below.
module secded_guard_props #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              enc_valid,
    input logic [71:0]       enc_word,
    input logic              rd_valid,
    input logic              cor_valid,
    input logic              err_single,
    input logic              err_double,
    input logic              log_clear,
    input logic              log_valid,
    input logic [ADDR_W-1:0] log_addr,
    input logic [7:0]        log_syn,
    input logic              io_rd_req,
    input logic              io_rd_ack
);
    // R1
    enc_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (enc_valid && (^enc_word == 1'b0)));

    // R2
    cor_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> cor_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!cor_valid && !err_single && !err_double));

    // R4
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && err_double));

    // R7
    log_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !log_clear) |=> (log_valid && $stable(log_addr) && $stable(log_syn)));

    // R8
    log_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_clear && !err_single && !err_double) |=> !log_valid);

    // R9
    io_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd_req |=> io_rd_ack);
endmodule

bind secded_guard secded_guard_props #(.ADDR_W(ADDR_W)) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .enc_valid  (enc_valid),
    .enc_word   (enc_word),
    .rd_valid   (rd_valid),
    .cor_valid  (cor_valid),
    .err_single (err_single),
    .err_double (err_double),
    .log_clear  (log_clear),
    .log_valid  (log_valid),
    .log_addr   (log_addr),
    .log_syn    (log_syn),
    .io_rd_req  (io_rd_req),
    .io_rd_ack  (io_rd_ack)
);

// File: tb/sim_secded_guard.sv
// Directed bench for secded_guard: one task per scenario, each self-checking.
module sim_secded_guard;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [63:0]       wr_data = '0;
    logic              enc_valid;
    logic [71:0]       enc_word;
    logic              rd_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [71:0]       rd_word = '0;
    logic              cor_valid;
    logic [63:0]       cor_data;
    logic              err_single;
    logic              err_double;
    logic              log_clear = 1'b0;
    logic              log_valid;
    logic              io_rd_req = 1'b0;
    logic              io_rd_ack;
    logic              io_rd_valid;
    logic [ADDR_W-1:0] io_rd_addr;
    logic [7:0]        io_rd_syn;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secded_guard #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .enc_valid(enc_valid), .enc_word(enc_word),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_word(rd_word),
        .cor_valid(cor_valid), .cor_data(cor_data),
        .err_single(err_single), .err_double(err_double),
        .log_clear(log_clear), .log_valid(log_valid),
        .io_rd_req(io_rd_req), .io_rd_ack(io_rd_ack),
        .io_rd_valid(io_rd_valid), .io_rd_addr(io_rd_addr), .io_rd_syn(io_rd_syn)
    );

    // Record one check
    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference codeword built from the R1 layout
    function automatic logic [71:0] model_enc(input logic [63:0] d);
        logic [71:0] cw;
        int j;
        cw = '0;
        j = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[j];
                j++;
            end
        end
        for (int k = 0; k < 7; k++) begin
            logic b;
            b = 1'b0;
            for (int p = 1; p < 72; p++) if ((p >> k) & 1) b = b ^ cw[p];
            cw[1 << k] = b;
        end
        cw[0] = ^cw[71:1];
        return cw;
    endfunction

    // Present one read; returns at the negedge where outputs are visible
    task automatic do_read(input logic [71:0] w, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        rd_valid = 1'b1; rd_word = w; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0; rd_word = '0;
    endtask

    // Snapshot the capture register through the IO port
    task automatic io_read();
        @(negedge clk);
        io_rd_req = 1'b1;
        @(negedge clk);
        io_rd_req = 1'b0;
        chk(io_rd_ack == 1'b1, "R9 ack", io_rd_ack, 1);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        log_clear = 1'b1;
        @(negedge clk);
        log_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk(!enc_valid && !cor_valid && !err_single && !err_double, "R10 strobes",
            {enc_valid, cor_valid, err_single, err_double}, 0);
        chk(!log_valid && !io_rd_ack, "R10 log", {log_valid, io_rd_ack}, 0);
    endtask

    task automatic t_encode(input logic [63:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(enc_valid, "R1 valid", enc_valid, 1);
        chk(enc_word == model_enc(d), "R1 word", enc_word, model_enc(d));
    endtask

    task automatic t_clean(input logic [63:0] d);
        do_read(model_enc(d), 32'h100);
        chk(cor_valid && cor_data == d, "R2 data", cor_data, d);
        chk(!err_single && !err_double, "R2 flags", {err_single, err_double}, 0);
    endtask

    task automatic t_single(input logic [63:0] d, input int pos);
        logic [71:0] w;
        w = model_enc(d);
        w[pos] = ~w[pos];
        do_read(w, 32'h200 + pos);
        chk(cor_data == d, "R3 corrected", cor_data, d);
        chk(err_single && !err_double, "R3 flags", {err_single, err_double}, 2'b10);
    endtask

    task automatic t_double(input logic [63:0] d, input int p1, input int p2);
        logic [71:0] w;
        w = model_enc(d);
        w[p1] = ~w[p1];
        w[p2] = ~w[p2];
        pulse_clear();
        do_read(w, 32'hD0D0);
        chk(err_double && !err_single, "R4 flags", {err_single, err_double}, 2'b01);
        @(negedge clk);
        io_read();
        chk(io_rd_valid && io_rd_syn == {1'b0, 7'(p1 ^ p2)}, "R5 double syndrome",
            io_rd_syn, {1'b0, 7'(p1 ^ p2)});
    endtask

    task automatic t_first_capture();
        logic [71:0] w;
        pulse_clear();
        io_read();
        chk(!io_rd_valid, "R8 cleared", io_rd_valid, 0);
        w = model_enc(64'h0123_4567_89AB_CDEF);
        w[37] = ~w[37];
        do_read(w, 32'hCAFE_0001);
        chk(!log_valid, "R6 capture lags flags", log_valid, 0);
        @(negedge clk);
        chk(log_valid, "R6 captured", log_valid, 1);
        io_read();
        chk(io_rd_addr == 32'hCAFE_0001, "R6 addr", io_rd_addr, 32'hCAFE_0001);
        chk(io_rd_syn == 8'h80 + 8'd37, "R5 single syndrome", io_rd_syn, 8'h80 + 8'd37);
        // R7: a later error does not overwrite
        w = model_enc(64'h5555);
        w[3] = ~w[3];
        w[9] = ~w[9];
        do_read(w, 32'hBEEF_0002);
        @(negedge clk);
        io_read();
        chk(io_rd_addr == 32'hCAFE_0001, "R7 addr held", io_rd_addr, 32'hCAFE_0001);
        chk(io_rd_syn == 8'h80 + 8'd37, "R7 syn held", io_rd_syn, 8'h80 + 8'd37);
    endtask

    task automatic t_clear_collide();
        logic [71:0] w;
        w = model_enc(64'hFFFF_0000_FFFF_0000);
        w[70] = ~w[70];
        do_read(w, 32'hA5A5_0003);
        log_clear = 1'b1;
        @(negedge clk);
        log_clear = 1'b0;
        chk(log_valid, "R8 collide valid", log_valid, 1);
        io_read();
        chk(io_rd_addr == 32'hA5A5_0003, "R8 collide addr", io_rd_addr, 32'hA5A5_0003);
        chk(io_rd_syn == 8'h80 + 8'd70, "R8 collide syn", io_rd_syn, 8'h80 + 8'd70);
    endtask

    task automatic t_idle();
        pulse_clear();
        @(negedge clk);
        rd_valid = 1'b0; rd_word = 72'hF0_0F00_0000_0000_0003; rd_addr = 32'h77;
        @(negedge clk);
        chk(!cor_valid && !err_single && !err_double, "R11 quiet",
            {cor_valid, err_single, err_double}, 0);
        @(negedge clk);
        chk(!log_valid, "R11 nothing captured", log_valid, 0);
        rd_word = '0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_encode(64'h0);
        t_encode(64'hFFFF_FFFF_FFFF_FFFF);
        t_encode(64'hDEAD_BEEF_1234_5678);
        t_clean(64'h0);
        t_clean(64'h8000_0000_0000_0001);
        for (int i = 0; i < 72; i++) t_single(64'hA5A5_5A5A_C3C3_3C3C ^ 64'(i), i);
        t_double(64'h1111_2222_3333_4444, 5, 60);
        t_double(64'h0, 0, 71);
        t_first_capture();
        t_clear_collide();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule